// File: doc/BRIEF.md
# Conversion Result Averager

This block sits between a converter's sequencer and its result register. Each conversion result arrives with a one-cycle strobe. When averaging is on, the block adds a programmable number of consecutive results and publishes their rounded mean as a single result. When averaging is off, every result is passed through as it arrives.

A whole averaged set counts as one conversion. While a set is still short of samples, the block asks the sequencer for the next conversion through a restart pulse. Once the set is complete, the restart pulse continues only in continuous mode. Each completion raises a sticky done flag and, if enabled, a DMA request. Reading the result clears both.

A start pulse arms the block and clears any partial sum. Samples that arrive while the block is idle are ignored.

Top module: `adc_avg_unit`

## Requirements
- R1: After reset, `res_data` is 0 and `done_flag`, `done_pulse`, `dma_req` and `restart` are all low.
- R2: With `avg_en` low, every accepted sample completes on its own, and `res_data` equals that sample.
- R3: With `avg_en` high, `avg_sel` values 0, 1, 2 and 3 select sets of 4, 8, 16 and 32 samples. `done_pulse` is high only after the last sample of a set.
- R4: The published mean is (sum + N/2) >> log2(N). A set of 32 samples of 0xFFFF yields 0xFFFF, so the sum never overflows.
- R5: With `cont_en` low, the block goes idle after one completed set (or one sample when `avg_en` is low). No restart follows the final sample, and later samples produce no completion.
- R6: With `cont_en` high, a restart pulse follows the final sample of a set, and the next set runs without a new start.
- R7: A restart pulse follows every accepted sample that is not the last of its set.
- R8: On each completion, `dma_req` is set to the value of `dma_en`. It stays high until the result is read.
- R9: A high `rd_strobe` clears `done_flag` and `dma_req` at the next edge. If a completion falls on the same edge, the completion wins.
- R10: A change of `avg_en` or `avg_sel` in the middle of a set discards the partial sum, and the set begins again.
- R11: Samples that arrive while the block is idle (not started) change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Arms the block and clears the partial sum |
| smp_valid | input | 1 | Strobe that marks a new conversion result |
| smp_data | input | DW | Conversion result |
| avg_en | input | 1 | Averaging enable |
| avg_sel | input | 2 | Set size select: 4, 8, 16 or 32 samples |
| cont_en | input | 1 | Continuous mode |
| dma_en | input | 1 | DMA request enable |
| rd_strobe | input | 1 | Result read; clears the flag and the request |
| res_data | output | DW | Latest published result |
| done_pulse | output | 1 | One-cycle completion pulse |
| done_flag | output | 1 | Sticky completion flag |
| dma_req | output | 1 | DMA request |
| restart | output | 1 | Request to the sequencer for another conversion |

## Verification
A sample that is strobed before a clock edge shows its effect right after that edge: `res_data`, `done_pulse`, `done_flag`, `dma_req` and `restart` all update at that edge. A read clears the flags at its own edge. A configuration change takes one edge to be taken up. The bench drives every input on the falling edge, holds it for one rising edge, and checks the outputs at the next falling edge. Each result is therefore compared in exactly the cycle it becomes due. Expected means come from a bench function that adds up the same randomly drawn samples.

// File: rtl/adc_avg_unit.sv
module adc_avg_unit #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic          avg_en,
  input  logic [1:0]    avg_sel,
  input  logic          cont_en,
  input  logic          dma_en,
  input  logic          rd_strobe,
  output logic [DW-1:0] res_data,
  output logic          done_pulse,
  output logic          done_flag,
  output logic          dma_req,
  output logic          restart
);
  localparam int CW = 5;
  localparam int AW = DW + CW;

  logic          active;
  logic [AW-1:0] acc;
  logic [CW-1:0] cnt;
  logic [2:0]    cfg_q;

  wire [2:0]    cfg      = {avg_en, avg_sel};
  wire          cfg_chg  = cfg != cfg_q;
  wire [2:0]    shamt    = avg_en ? ({1'b0, avg_sel} + 3'd2) : 3'd0;
  wire [CW:0]   n_smp    = {{CW{1'b0}}, 1'b1} << shamt;
  wire [CW:0]   n_m1     = n_smp - {{CW{1'b0}}, 1'b1};
  wire [CW-1:0] last_idx = n_m1[CW-1:0];
  wire          take     = active && smp_valid && !cfg_chg && !start;
  wire          fin      = take && (cnt == last_idx);
  wire [AW-1:0] sum      = acc + {{CW{1'b0}}, smp_data};
  wire [AW-1:0] rounded  = sum + {{(AW-CW-1){1'b0}}, n_smp >> 1};
  wire [AW-1:0] mean     = rounded >> shamt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      acc        <= '0;
      cnt        <= '0;
      cfg_q      <= '0;
      res_data   <= '0;
      done_pulse <= 1'b0;
      done_flag  <= 1'b0;
      dma_req    <= 1'b0;
      restart    <= 1'b0;
    end else begin
      cfg_q      <= cfg;
      done_pulse <= fin;
      restart    <= take && (!fin || cont_en);
      if (start) begin
        active <= 1'b1;
        acc    <= '0;
        cnt    <= '0;
      end else if (cfg_chg) begin
        acc <= '0;
        cnt <= '0;
      end else if (take) begin
        if (fin) begin
          acc      <= '0;
          cnt      <= '0;
          active   <= cont_en;
          res_data <= mean[DW-1:0];
        end else begin
          acc <= sum;
          cnt <= cnt + 1'b1;
        end
      end
      if (fin) begin
        done_flag <= 1'b1;
        dma_req   <= dma_en;
      end else if (rd_strobe) begin
        done_flag <= 1'b0;
        dma_req   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_avg_unit_sva.sv
module adc_avg_unit_sva #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cont_en,
  input logic          dma_en,
  input logic          rd_strobe,
  input logic [DW-1:0] res_data,
  input logic          done_pulse,
  input logic          done_flag,
  input logic          dma_req,
  input logic          restart
);
  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> done_flag); // R3
  AST_RES_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !done_pulse |-> $stable(res_data)); // R4
  AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && !$past(cont_en)) |-> !restart); // R5
  AST_DMA_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req) |-> $past(dma_en)); // R8
  AST_DMA_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> done_flag); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> (!done_flag || done_pulse)); // R9
endmodule

bind adc_avg_unit adc_avg_unit_sva #(.DW(DW)) u_sva (
  .clk(clk), .rst_n(rst_n), .cont_en(cont_en), .dma_en(dma_en),
  .rd_strobe(rd_strobe), .res_data(res_data), .done_pulse(done_pulse),
  .done_flag(done_flag), .dma_req(dma_req), .restart(restart)
);

// File: tb/adc_avg_unit_bench.sv
module adc_avg_unit_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, smp_valid = 0, avg_en = 0, cont_en = 0, dma_en = 0, rd_strobe = 0;
  logic [1:0] avg_sel = 0;
  logic [15:0] smp_data = 0;
  logic [15:0] res_data;
  logic done_pulse, done_flag, dma_req, restart;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  adc_avg_unit u_adc_avg_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .smp_valid(smp_valid), .smp_data(smp_data),
    .avg_en(avg_en), .avg_sel(avg_sel), .cont_en(cont_en), .dma_en(dma_en),
    .rd_strobe(rd_strobe), .res_data(res_data), .done_pulse(done_pulse),
    .done_flag(done_flag), .dma_req(dma_req), .restart(restart));

  function automatic logic [15:0] exp_mean(input int unsigned s, input logic [1:0] sel);
    int unsigned n = 4 << sel;
    return 16'((s + n / 2) >> (sel + 2));
  endfunction

  task automatic check(input string req, input int unsigned act, input int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic kick();
    start = 1; @(negedge clk); start = 0;
  endtask

  task automatic read_res();
    rd_strobe = 1; @(negedge clk); rd_strobe = 0;
  endtask

  task automatic sample(input logic [15:0] d);
    smp_valid = 1; smp_data = d; @(negedge clk); smp_valid = 0;
  endtask

  task automatic run_set(input logic [1:0] sel, input bit rnd, input logic [15:0] fixed);
    int n = 4 << sel;
    int unsigned s = 0;
    for (int i = 0; i < n; i++) begin
      logic [15:0] d = rnd ? 16'($urandom) : fixed;
      s += d;
      sample(d);
      if (i < n - 1) begin
        check("R3 no early done", done_pulse, 0);
        check("R7 restart mid-set", restart, 1);
      end else begin
        check("R3 done on last", done_pulse, 1);
        check("R4 mean", res_data, exp_mean(s, sel));
        check("R5/R6 restart after final", restart, cont_en);
        check("R8 dma on done", dma_req, dma_en);
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle(2);
    rst_n = 1;
    idle(1);
    check("R1 res", res_data, 0);
    check("R1 flags", {done_flag, done_pulse, dma_req, restart}, 0);

    sample(16'h1111);
    check("R11 idle sample ignored", done_pulse, 0);
    check("R11 idle no restart", restart, 0);

    kick();
    sample(16'h1234);
    check("R2 pass-through done", done_pulse, 1);
    check("R2 pass-through value", res_data, 16'h1234);
    check("R5 no restart single", restart, 0);
    sample(16'h5555);
    check("R5 stopped after one", done_pulse, 0);
    check("R5 result kept", res_data, 16'h1234);
    read_res();
    check("R9 flag cleared", done_flag, 0);

    avg_en = 1; dma_en = 1;
    for (int sel = 0; sel < 4; sel++) begin
      avg_sel = 2'(sel); idle(1);
      kick();
      run_set(2'(sel), 1, 0);
      read_res();
      check("R9 read clears flag", done_flag, 0);
      check("R9 read clears dma", dma_req, 0);
    end

    avg_sel = 3; idle(1); kick();
    run_set(3, 0, 16'hFFFF);
    check("R4 full scale", res_data, 16'hFFFF);

    avg_sel = 0; dma_en = 0; idle(1); kick();
    sample(1); sample(1); sample(0); sample(0);
    check("R4 round up", res_data, 1);
    check("R8 no dma when disabled", dma_req, 0);
    kick();
    sample(1); sample(0); sample(0); sample(0);
    check("R4 round down", res_data, 0);

    dma_en = 1; cont_en = 1; kick();
    run_set(0, 1, 0);
    run_set(0, 1, 0);
    check("R6 second set ran", done_flag, 1);
    cont_en = 0;
    run_set(0, 1, 0);
    sample(16'h7777);
    check("R5 idle after continuous off", done_pulse, 0);

    avg_sel = 0; idle(1); kick();
    sample(16'hF000); sample(16'hF000);
    avg_sel = 1; idle(1);
    run_set(1, 0, 16'h0100);
    check("R10 partial discarded", res_data, 16'h0100);

    avg_sel = 0; idle(1); kick();
    read_res();
    sample(10); sample(20); sample(30);
    rd_strobe = 1; sample(40); rd_strobe = 0;
    check("R9 completion wins", done_flag, 1);
    check("R9 value", res_data, 25);
    read_res();

    for (int k = 0; k < 20; k++) begin
      avg_sel = 2'($urandom); dma_en = 1'($urandom); idle(1);
      kick();
      run_set(avg_sel, 1, 0);
      read_res();
      check("R9 random read", {done_flag, dma_req}, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule